// File: doc/BRIEF.md
# Serial Flash Read Engine

This block reads a run of bytes out of a serial NOR flash. A start pulse carries a 24-bit byte address and a byte count. The engine then lowers chip select, sends a read opcode and the address, inserts dummy clocks if the chosen read mode needs them, and gathers the returned data. Each byte is handed out on `rd_byte` with a one-cycle `rd_vld` strobe. `busy` stays high until the transfer has closed.

A packed configuration byte sets the serial clock rate, the idle level of the clock, and two independent edge choices: one for changing outgoing bits and one for capturing incoming bits. A 2-bit read-mode index picks the opcode, the dummy-clock count and the data-lane width. An override input forces the fastest clock and ignores the rate field. The serial clock is built from a reference clock that runs at twice the fastest serial rate. Each rate is an exact 50% duty division of that reference.

Top module: `sfr_engine`

## Requirements
- R1: After reset and while idle, `cs_n` is 1, `busy` is 0, `rd_vld` is 0 and `io_oe` is 0.
- R2: While chip select is low, each high and each low phase of `sclk` lasts H reference cycles. With the override clear, H is 2, 4, 6 or 8 for `cfg_byte[1:0]` = 0, 1, 2 or 3.
- R3: With `fast_ovr` set, H is 1 whatever `cfg_byte[1:0]` holds.
- R4: `cfg_byte[5]` is the idle level of `sclk`. The idle level is the level `sclk` has while chip select is high. The leading edge of a clock leaves the idle level and the trailing edge returns to it.
- R5: With `cfg_byte[6]`=0, outgoing bits change on trailing edges, and the first bit is present before the first leading edge. With `cfg_byte[6]`=1, outgoing bits change on leading edges.
- R6: With `cfg_byte[7]`=0, incoming data is captured on leading edges. With `cfg_byte[7]`=1, it is captured on trailing edges.
- R7: The read-mode index selects the following, and the transfer then has exactly 32 + dummy + 8·count/lanes clocks:

  | Index | Opcode | Dummy clocks | Data lanes |
  |-------|--------|--------------|------------|
  | 0 | 0x03 | 0 | 1 |
  | 1 | 0x0B | 8 | 1 |
  | 2 | 0x3B | 8 | 2 |
  | 3 | 0x6B | 8 | 4 |
- R8: The opcode and then the 24-bit address go out most significant bit first on `io_out[0]`, with `io_oe[0]`=1. `io_oe[0]` drops once the last address bit is done. `io_oe[3:1]` is always 0.
- R9: Single-lane data enters on `io_in[1]`. Dual-lane data uses `io_in[1:0]` and quad-lane data uses `io_in[3:0]`. The higher lane carries the higher bit, and earlier captures are more significant.
- R10: Exactly `count` bytes are delivered, each with a one-cycle `rd_vld` pulse, in flash address order.
- R11: `cs_n` falls and `busy` rises the cycle after an accepted start. The first edge comes H cycles later. `cs_n` rises and `busy` falls together, H cycles after the last trailing edge.
- R12: A start pulse while `busy` is high is ignored.
- R13: The configuration, override, mode, address and count are sampled at the accepted start. Changing them during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte | input | 8 | Packed configuration: rate [1:0], idle level [5], drive edge [6], capture edge [7] |
| fast_ovr | input | 1 | Forces the fastest serial clock |
| rd_mode | input | 2 | Read-mode index |
| start | input | 1 | One-cycle start request |
| addr | input | 24 | Flash byte address |
| count | input | CNT_W | Number of bytes to read |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Outgoing lane values |
| io_oe | output | 4 | Output enables per lane |
| io_in | input | 4 | Incoming lane values |
| rd_byte | output | 8 | Received byte |
| rd_vld | output | 1 | Byte strobe |
| busy | output | 1 | Transfer in progress |

## Verification
Suppose the edge counter or the stored clock total is wrong. The number of leading edges seen per transfer then differs from the mode formula, and `cs_n` rises early or late within one half-period of the error. A bad drive-edge choice shifts the command by one bit, so the address the flash model decodes is wrong. Its data then differs from the first byte on. A capture on the wrong edge or lane, or a stale sub-byte count, corrupts the first byte, and that shows on the first `rd_vld` pulse.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int HALF_W = 4;   // holds the largest half period, 8
  localparam int CMD_W  = 32;  // opcode plus 24-bit address

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} sfr_state_e;

  function automatic logic [7:0] mode_opcode(input logic [1:0] m);
    case (m)
      2'd0:    return 8'h03;
      2'd1:    return 8'h0B;
      2'd2:    return 8'h3B;
      default: return 8'h6B;
    endcase
  endfunction

  function automatic logic [3:0] mode_dummy(input logic [1:0] m);
    return (m == 2'd0) ? 4'd0 : 4'd8;
  endfunction

  // log2 of the data lane count
  function automatic logic [1:0] mode_lshift(input logic [1:0] m);
    case (m)
      2'd2:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] half_of(input logic ovr, input logic [1:0] f);
    return ovr ? HALF_W'(1) : HALF_W'((HALF_W'(f) + HALF_W'(1)) << 1);
  endfunction
endpackage

// File: rtl/sfr_tick.sv
module sfr_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] half,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == half - W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + W'(1);
  end

  // R2: ticks are at least two cycles apart unless the half period is one
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && half != W'(1)) |=> !tick);
endmodule

// File: rtl/sfr_cmd_tx.sv
module sfr_cmd_tx #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          lead_mode,
  input  logic [CW-1:0] cmd,
  input  logic          shift,
  input  logic          clr,
  output logic          bit_o,
  output logic          oe_o
);
  localparam int RW = $clog2(CW + 2);
  logic [CW:0]   sh;
  logic [RW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh  <= '0;
      rem <= '0;
    end else if (load) begin
      // leading-edge drive: an empty slot first, so the first shift shows bit 31
      sh  <= lead_mode ? {1'b0, cmd} : {cmd, 1'b0};
      rem <= lead_mode ? RW'(CW + 1) : RW'(CW);
    end else if (shift && rem != '0) begin
      sh  <= sh << 1;
      rem <= rem - RW'(1);
    end
  end

  assign bit_o = sh[CW];
  assign oe_o  = (rem != '0);

  // R8: the enable only comes back through a new load
  p_oe_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!oe_o && !load) |=> !oe_o);
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       cap,
  input  logic [1:0] lsh,
  input  logic [3:0] lanes,
  output logic [7:0] byte_o,
  output logic       vld_o
);
  logic [7:0] acc, nxt;
  logic [2:0] sub;
  logic       last;

  always_comb begin
    case (lsh)
      2'd0:    nxt = {acc[6:0], lanes[1]};
      2'd1:    nxt = {acc[5:0], lanes[1:0]};
      default: nxt = {acc[3:0], lanes};
    endcase
  end

  assign last = (sub == (3'd7 >> lsh));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      sub    <= '0;
      byte_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (clear) begin
        acc <= '0;
        sub <= '0;
      end else if (cap) begin
        acc <= nxt;
        if (last) begin
          sub    <= '0;
          byte_o <= nxt;
          vld_o  <= 1'b1;
        end else begin
          sub <= sub + 3'd1;
        end
      end
    end
  end

  // R10: each byte strobe is a single-cycle pulse
  p_vld_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);
endmodule

// File: rtl/sfr_engine.sv
module sfr_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       cfg_byte,
  input  logic             fast_ovr,
  input  logic [1:0]       rd_mode,
  input  logic             start,
  input  logic [23:0]      addr,
  input  logic [CNT_W-1:0] count,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in,
  output logic [7:0]       rd_byte,
  output logic             rd_vld,
  output logic             busy
);
  import sfr_pkg::*;

  localparam int EW = CNT_W + 6;

  sfr_state_e        st;
  logic [HALF_W-1:0] half_q;
  logic              cpol_q, smp_trail_q, drv_lead_q;
  logic [1:0]        lsh_q;
  logic [EW-1:0]     e_q, last_q;
  logic [EW-2:0]     cstart_q;

  logic          tick, accept, lead, drv_ev, cap_ev, finish, tx_bit, tx_oe;
  logic [1:0]    lsh_new;
  logic [EW-1:0] clocks_new;
  logic          cfg_unused;

  assign cfg_unused = ^cfg_byte[4:2];
  assign accept     = (st == ST_IDLE) && start;
  assign lsh_new    = mode_lshift(rd_mode);
  assign clocks_new = EW'(CMD_W) + EW'(mode_dummy(rd_mode))
                    + (EW'(count) << (2'd3 - lsh_new));

  assign lead   = ~e_q[0];
  assign drv_ev = tick && (st == ST_RUN) && (drv_lead_q ? lead : ~lead);
  assign cap_ev = tick && (st == ST_RUN) && (smp_trail_q ? ~lead : lead)
                  && (e_q[EW-1:1] >= cstart_q);
  assign finish = tick && (st == ST_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      sclk        <= cfg_byte[5];
      cs_n        <= 1'b1;
      busy        <= 1'b0;
      e_q         <= '0;
      last_q      <= '0;
      cstart_q    <= '0;
      half_q      <= HALF_W'(1);
      cpol_q      <= 1'b0;
      smp_trail_q <= 1'b0;
      drv_lead_q  <= 1'b0;
      lsh_q       <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          sclk <= cfg_byte[5];
          if (start) begin
            half_q      <= half_of(fast_ovr, cfg_byte[1:0]);
            cpol_q      <= cfg_byte[5];
            drv_lead_q  <= cfg_byte[6];
            smp_trail_q <= cfg_byte[7];
            lsh_q       <= lsh_new;
            cstart_q    <= (EW-1)'(CMD_W) + (EW-1)'(mode_dummy(rd_mode));
            last_q      <= (clocks_new << 1) - EW'(1);
            e_q         <= '0;
            cs_n        <= 1'b0;
            busy        <= 1'b1;
            st          <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            sclk <= ~sclk;
            e_q  <= e_q + EW'(1);
            if (e_q == last_q) st <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  sfr_tick #(.W(HALF_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (st != ST_IDLE),
    .half (half_q),
    .tick (tick)
  );

  sfr_cmd_tx #(.CW(CMD_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .lead_mode (cfg_byte[6]),
    .cmd       ({mode_opcode(rd_mode), addr}),
    .shift     (drv_ev),
    .clr       (finish),
    .bit_o     (tx_bit),
    .oe_o      (tx_oe)
  );

  sfr_rx u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .cap    (cap_ev),
    .lsh    (lsh_q),
    .lanes  (io_in),
    .byte_o (rd_byte),
    .vld_o  (rd_vld)
  );

  assign io_out = {3'b000, tx_bit};
  assign io_oe  = {3'b000, tx_oe};

  // R11: busy only rises in answer to a start pulse
  p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R10: bytes are only delivered inside a transfer
  p_vld_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> busy);
  // R8: the command lane is driven only under chip select
  p_oe_needs_cs_r8: assert property (@(posedge clk) disable iff (rst)
    io_oe[0] |-> !cs_n);
  // R2: the serial clock moves only on a tick
  p_sclk_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !tick) |=> $stable(sclk));
  // R4: while idle the clock sits at the configured level
  p_idle_level_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> sclk == $past(cfg_byte[5]));
endmodule

// File: tb/sim_sfr_engine.sv
module sim_sfr_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_byte = 8'h00;
  logic        fast_ovr = 1'b0;
  logic [1:0]  rd_mode = 2'd0;
  logic        start = 1'b0;
  logic [23:0] addr = 24'h0;
  logic [15:0] count = 16'h0;
  logic        sclk, cs_n, rd_vld, busy;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = 4'h0;
  logic [7:0]  rd_byte;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  sfr_engine u0 (
    .clk(clk), .rst(rst), .cfg_byte(cfg_byte), .fast_ovr(fast_ovr),
    .rd_mode(rd_mode), .start(start), .addr(addr), .count(count),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
    .rd_byte(rd_byte), .rd_vld(rd_vld), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a, input int b);
    return a[7:0] ^ a[15:8] ^ 8'(b * 29 + 108);
  endfunction

  function automatic logic [3:0] beat(input logic [23:0] a, input int j, input int lanes);
    int per = 8 / lanes;
    logic [7:0] bv = pat(a, j / per);
    logic [7:0] v  = (bv >> (8 - lanes * ((j % per) + 1))) & 8'((1 << lanes) - 1);
    if (lanes == 1) return {2'b00, v[0], 1'b0};
    return v[3:0];
  endfunction

  task automatic xfer(input logic [7:0] cfg, input bit ovr, input logic [1:0] md,
                      input logic [23:0] a, input int n, input bit poke);
    int  hp    = ovr ? 1 : (int'(cfg[1:0]) + 1) * 2;
    bit  cpol  = cfg[5];
    bit  dl    = cfg[6];
    bit  sl    = cfg[7];
    int  lanes = (md == 2'd3) ? 4 : (md == 2'd2) ? 2 : 1;
    int  c0    = (md == 2'd0) ? 32 : 40;
    int  nclk  = c0 + n * (8 / lanes);
    int  t = 0, last = 0, leads = 0, nrx = 0, cidx = 0, j = 0;
    bit  prev = cpol, lead = 0;
    bit  e_half = 0, e_cmdoe = 0, e_oe = 0, e_lane = 0, e_tail = 0;
    int  e_data = 0;
    logic [7:0]  bad_act = 0, bad_exp = 0;
    logic [31:0] cmd = 0;
    @(negedge clk);
    cfg_byte = cfg; fast_ovr = ovr; rd_mode = md; addr = a; count = 16'(n); io_in = 4'h0;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == cpol && cs_n && !busy, "R4 idle level", sclk, cpol);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R11 select after start", {cs_n, busy}, 2'b01);
    while (t < 20000) begin
      @(negedge clk);
      t++;
      if (poke && t == 5) begin
        start = 1'b1; addr = ~a; cfg_byte = ~cfg; rd_mode = ~md;
        fast_ovr = ~ovr; count = 16'(n + 2);
      end
      if (poke && t == 6) start = 1'b0;
      if (io_oe[3:1] != 3'b000) e_lane = 1;
      if (rd_vld) begin
        if (rd_byte != pat(a, nrx) && e_data == 0) begin
          bad_act = rd_byte; bad_exp = pat(a, nrx);
        end
        if (rd_byte != pat(a, nrx)) e_data++;
        nrx++;
      end
      if (cs_n) begin
        if (t - last != hp) e_tail = 1;
        break;
      end
      if (sclk != prev) begin
        if (t - last != hp) e_half = 1;
        last = t;
        prev = sclk;
        lead = (sclk != cpol);
        if (lead) begin cidx = leads; leads++; end
        else cidx = leads - 1;
        if (lead == !dl && cidx < 32) begin
          cmd = {cmd[30:0], io_out[0]};
          if (!io_oe[0]) e_cmdoe = 1;
        end
        if (cidx >= 33 && io_oe[0]) e_oe = 1;
        if (lead == sl) begin
          j = sl ? cidx - c0 : cidx + 1 - c0;
          if (j >= 0 && j < n * (8 / lanes)) io_in = beat(cmd[23:0], j, lanes);
        end
      end
    end
    chk(!e_half, ovr ? "R3 forced half period" : "R2 half period", e_half, 0);
    chk(cmd[31:24] == 8'(md == 0 ? 8'h03 : md == 1 ? 8'h0B : md == 2 ? 8'h3B : 8'h6B),
        "R7 opcode", cmd[31:24], md);
    chk(cmd[23:0] == a, "R5 R8 address bits on drive edge", cmd[23:0], a);
    chk(!e_cmdoe && !e_oe && !e_lane, "R8 output enables", {e_cmdoe, e_oe, e_lane}, 0);
    chk(e_data == 0, "R6 R9 captured data", bad_act, bad_exp);
    chk(nrx == n, "R10 byte count", nrx, n);
    chk(leads == nclk, "R7 clock count", leads, nclk);
    chk(!e_tail && !busy && sclk == cpol, "R11 release timing", {e_tail, busy, sclk}, {2'b00, cpol});
    if (poke) chk(cmd[23:0] == a && nrx == n && !e_half, "R12 R13 held during transfer", nrx, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(cs_n && !busy && !rd_vld && io_oe == 4'h0, "R1 reset state",
        {cs_n, busy, rd_vld, io_oe}, 7'b1000000);
    chk(sclk == cfg_byte[5], "R4 reset idle level", sclk, cfg_byte[5]);
    for (int i = 0; i < 40; i++) begin
      int  sel = i % 5;
      logic [1:0] fld = (sel < 4) ? 2'(sel) : 2'(i);
      logic [7:0] cfg = {i[4], i[3], i[2], 3'b101, fld};
      xfer(cfg, sel == 4, 2'(i), 24'h1A2B00 + 24'(i) * 24'h010307, 1 + i % 3, (i % 4) == 3);
    end
    xfer(8'h00, 1'b1, 2'd3, 24'hC0FFEE, 20, 1'b0);
    xfer(8'h63, 1'b0, 2'd0, 24'h000100, 0, 1'b0);
    xfer(8'hA2, 1'b0, 2'd2, 24'hFFFFFF, 5, 1'b1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule